// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles instead of in one wide combinational array. A request is offered on `start_i` together with the operands `a_i` and `b_i`. The request is taken only while `ready_o` is high, and the block then captures both operands. On each following clock it consumes `STEP` bits of the multiplier operand `a_i`, starting from the least significant end. For each of those bits that is set, it adds the multiplicand `b_i`, shifted to the right bit position, into a product register of `A_W + B_W` bits.

The block stops as soon as the multiplier bits still to be consumed are all zero. The latency therefore depends on the position of the highest set bit of `a_i`, and `ceil(A_W/STEP)` cycles is only an upper bound. If either operand is zero, the block finishes in the cycle of acceptance. With `STEP = 1` there is a single adder per cycle. A larger `STEP` uses a group of `STEP` shifted terms feeding one sum, which costs more area and takes proportionally fewer cycles.

Handshake rules: the input side is a valid/ready pair. `start_i` is the valid signal and `ready_o` is the ready signal. A request is accepted on a rising clock edge where both are high. While `ready_o` is low, `start_i` and the operands are ignored and need not be held. The output side has no back-pressure. `done_o` is a level that stays high, and `product_o` stays unchanged, until the next request is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `product_o` is 0.
- R2: A request is accepted on a rising edge where `start_i` and `ready_o` are both 1. On that edge `done_o` falls and `product_o` is cleared. If both operands are non-zero, `ready_o` falls on the same edge.
- R3: When `done_o` is high, `product_o` equals the unsigned product `a_i * b_i` of the accepted operands, `A_W + B_W` bits wide with no truncation.
- R4: For non-zero operands, `done_o` rises `ceil(n/STEP)` clock edges after the accepting edge, where `n` is the index of the highest set bit of `a_i` plus one. This is the early termination.
- R5: No computation takes longer than `ceil(A_W/STEP)` clock edges after the accepting edge.
- R6: If `a_i` or `b_i` is zero at acceptance, `done_o` is 1 and `product_o` is 0 right after the accepting edge, and `ready_o` stays 1.
- R7: While `ready_o` is 0, `start_i` and the operand inputs have no effect on the result or on the cycle in which `done_o` rises.
- R8: While `start_i` is low, `done_o` stays high and `product_o` stays unchanged once the result is complete.
- R9: `ready_o` is 0 exactly while a computation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request valid; accepted together with `ready_o` |
| a_i | input | A_W | Multiplier operand; its bits are consumed `STEP` per cycle |
| b_i | input | B_W | Multiplicand operand |
| ready_o | output | 1 | High when a new request can be accepted |
| done_o | output | 1 | Result complete; held until the next accepted request |
| product_o | output | A_W+B_W | Product register |

## Verification
A wrong multiplier shift or a wrong multiplicand alignment gives a wrong `product_o` at the first `done_o` after the fault. A stuck termination test shows up as `done_o` rising in the wrong cycle, too early or too late, so every test measures the latency edge by edge and compares it with `ceil(n/STEP)`. Mishandling of `start_i` while busy shows up as a changed product or a changed latency on that same request.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/mul_operands.sv
module mul_operands #(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter int STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [STEP-1:0]  low_bits,
  output logic [A_W+B_W-1:0] mcand,
  output logic             rest_zero
);
  import shift_add_mul_pkg::*;

  localparam int P_W = A_W + B_W;
  localparam int MW  = ceil_div(A_W, STEP) * STEP;

  logic [MW-1:0] mplier;
  logic [MW-1:0] mplier_rest;

  assign mplier_rest = mplier >> STEP;
  assign low_bits    = mplier[STEP-1:0];
  assign rest_zero   = (mplier_rest == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier <= '0;
      mcand  <= '0;
    end else if (load) begin
      mplier <= MW'(a_in);
      mcand  <= P_W'(b_in);
    end else if (step) begin
      mplier <= mplier_rest;
      mcand  <= mcand << STEP;
    end
  end

  // While stepping, the multiplier operand only ever loses set bits
  AST_MPLIER_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) && !$past(load) |-> ($countones(mplier) <= $countones($past(mplier)))); // R4

endmodule

// File: rtl/mul_ppsum.sv
module mul_ppsum #(
  parameter int P_W  = 16,
  parameter int STEP = 3
) (
  input  logic [P_W-1:0]  acc,
  input  logic [P_W-1:0]  mcand,
  input  logic [STEP-1:0] bits,
  output logic [P_W-1:0]  sum
);

  logic [P_W-1:0] term [STEP];

  for (genvar g = 0; g < STEP; g++) begin : g_term
    assign term[g] = bits[g] ? (mcand << g) : '0;
  end

  always_comb begin
    sum = acc;
    for (int i = 0; i < STEP; i++) begin
      sum = sum + term[i];
    end
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic a_zero,
  input  logic b_zero,
  input  logic rest_zero,
  output logic load,
  output logic step,
  output logic ready,
  output logic done
);
  import shift_add_mul_pkg::*;

  mul_state_t state;
  logic       accept;

  assign ready  = (state == ST_IDLE);
  assign accept = start && ready;
  assign load   = accept;
  assign step   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (a_zero || b_zero) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (rest_zero) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8

  AST_DONE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step) || $past(accept)); // R2

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !done); // R9

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter int STEP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [A_W+B_W-1:0] product_o
);
  import shift_add_mul_pkg::*;

  localparam int P_W    = A_W + B_W;
  localparam int NSTEPS = ceil_div(A_W, STEP);
  localparam int CW     = $clog2(NSTEPS + 2);

  logic            load, step, rest_zero;
  logic [STEP-1:0] low_bits;
  logic [P_W-1:0]  mcand, acc, sum;

  mul_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .a_zero    (a_i == '0),
    .b_zero    (b_i == '0),
    .rest_zero (rest_zero),
    .load      (load),
    .step      (step),
    .ready     (ready_o),
    .done      (done_o)
  );

  mul_operands #(.A_W(A_W), .B_W(B_W), .STEP(STEP)) u_ops (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .a_in      (a_i),
    .b_in      (b_i),
    .low_bits  (low_bits),
    .mcand     (mcand),
    .rest_zero (rest_zero)
  );

  mul_ppsum #(.P_W(P_W), .STEP(STEP)) u_sum (
    .acc   (acc),
    .mcand (mcand),
    .bits  (low_bits),
    .sum   (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= '0;
    end else if (step) begin
      acc <= sum;
    end
  end

  assign product_o = acc;

  // Cycle counter used only by the latency-bound check
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (load) begin
      run_cnt <= '0;
    end else if (step) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (run_cnt < CW'(NSTEPS))); // R5

  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && ready_o && (a_i == '0 || b_i == '0) |=> done_o && ready_o && (product_o == '0)); // R6

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> $stable(product_o)); // R8

endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  localparam int A_W  = 8;
  localparam int B_W  = 8;
  localparam int STEP = 3;
  localparam int P_W  = A_W + B_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [A_W-1:0] a_i = '0;
  logic [B_W-1:0] b_i = '0;
  logic ready_o, done_o;
  logic [P_W-1:0] product_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  shift_add_mul #(.A_W(A_W), .B_W(B_W), .STEP(STEP)) u_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .ready_o(ready_o), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int a, input int b);
    int n = 0;
    if (a == 0 || b == 0) return 0;
    for (int i = 0; i < A_W; i++) if (a[i]) n = i + 1;
    return (n + STEP - 1) / STEP;
  endfunction

  // Offers a request at a falling edge and counts edges until done; start is
  // dropped after acceptance unless busy_poke is set (then random junk is driven)
  task automatic run_mul(input int a, input int b, input bit busy_poke, input string tag);
    int cnt = 0;
    @(negedge clk);
    start_i = 1'b1; a_i = A_W'(a); b_i = B_W'(b);
    check({tag, " R2 ready before accept"}, ready_o, 1);
    @(posedge clk);
    @(negedge clk);
    if (busy_poke) begin
      a_i = 8'h03; b_i = 8'h05;
    end else begin
      start_i = 1'b0;
    end
    if (exp_lat(a, b) != 0) check({tag, " R9 ready low while busy"}, ready_o, 0);
    while (!done_o && cnt < 50) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    check({tag, " R4 latency"}, cnt, exp_lat(a, b));
    check({tag, " R5 bound"}, (cnt <= (A_W + STEP - 1) / STEP), 1);
    check({tag, " R3 product"}, product_o, longint'(a) * longint'(b));
    check({tag, " R9 ready at done"}, ready_o, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 ready", ready_o, 1);
    check("R1 done", done_o, 0);
    check("R1 product", product_o, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_basic();
    run_mul(13, 11, 0, "basic");
    run_mul(255, 255, 0, "max");
    run_mul(6, 200, 0, "small");
    run_mul(8'h80, 3, 0, "msb");
  endtask

  task automatic t_early();
    run_mul(1, 99, 0, "early1");
    run_mul(7, 99, 0, "early7");
    run_mul(8, 99, 0, "early8");
    run_mul(8'h3F, 77, 0, "early63");
  endtask

  task automatic t_zero();
    run_mul(0, 123, 0, "R6 a0");
    run_mul(45, 0, 0, "R6 b0");
  endtask

  task automatic t_busy();
    run_mul(8'hFF, 8'hFF, 1, "R7 poke");
    run_mul(9, 17, 1, "R7 poke2");
  endtask

  task automatic t_hold();
    logic [P_W-1:0] held;
    run_mul(21, 34, 0, "hold");
    held = product_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_i = A_W'(i * 37); b_i = B_W'(i * 11);
      check("R8 done held", done_o, 1);
      check("R8 product held", product_o, held);
    end
    @(negedge clk);
    start_i = 1'b1; a_i = 8'd200; b_i = 8'd3;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R2 done cleared", done_o, 0);
    check("R2 product cleared", product_o, 0);
    while (!done_o) @(negedge clk);
    check("R3 after restart", product_o, 600);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_early();
    t_zero();
    t_busy();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule